// File: doc/BRIEF.md
# Register Redirect and Predicate Lookup

This block sits beside the decode stage of a scalar core that runs each instruction over a loop of elements. It holds two small key-value tables. Register entries say whether a register named in an opcode is a vector, and where its data really lives. Predicate entries name the integer register that holds the element mask for a given opcode register. Software loads up to `DEPTH` entries into each table. The block expands each entry into a 32-slot array that is indexed by key register, with one array set for integer registers and one for floating-point registers. A lookup is then a single index operation, with no search across the entries.

For each lookup the block returns three results. The redirected register index, the vector flag and the element-width code are combinational, in the same cycle. The predicate register number goes out on an integer register-file read port in that same cycle. One cycle later, when the read data returns, the block applies inversion, the zeroing flag, the fail-on-first flag and the check for the reserved encoding. It then presents the finished mask.

Top module: `regpred_lookup`

## Requirements
- R1: After reset, every entry is disabled. A lookup of any register returns that register number zero-extended to 7 bits, with vector flag 0 and element-width code 0.
- R2: A register entry is 16 bits: [15:11] key register, [10] 1 = floating-point file, [9:8] element-width code, [7] vector flag, [6:0] target index. A write takes effect for lookups in the next cycle. For an enabled entry with the vector flag set, the redirect output is the target index. For a scalar entry, the redirect output is the opcode register number. The element-width output is the entry's code, or 0 when no entry exists.
- R3: Entries apply only to lookups whose int/fp flag matches the entry's type bit. The same key may hold different entries in the two files.
- R4: A later accepted entry with the same key and type replaces the earlier one.
- R5: Each table accepts at most `DEPTH` writes after reset or a clear. Further writes to that table are ignored.
- R6: A clear disables every entry of both tables, and its effect is visible in the next cycle. A write in the same cycle as a clear is ignored.
- R7: During a lookup, the read port address equals the predicate register of the matching predicate entry, or 0 if no entry matches. The mask, flags and `pred_valid_o` appear exactly one cycle after `lk_valid_i`.
- R8: When the looked-up register has no enabled register entry, or no enabled predicate entry, the mask is all ones and the zeroing, fail-on-first and illegal outputs are 0.
- R9: A predicate entry is 16 bits: [15:9] target register (bits [13:9] are matched against the opcode register), [8] 1 = floating-point file, [7] zeroing, [6] invert, [5] fail-on-first, [4:0] predicate register. When invert is set, every bit of the fetched value is complemented.
- R10: Predicate register 0 always reads as zero. With invert set and zeroing clear, it therefore gives an all-ones mask.
- R11: A matching entry with predicate register 0, zeroing set and invert set is reserved. It raises `pred_illegal_o` with the result, and forces the mask to 0 and the zeroing and fail-on-first outputs to 0.
- R12: For a valid non-reserved match, the entry's zeroing and fail-on-first bits appear with the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_clear_i | input | 1 | Disable all entries of both tables |
| reg_wr_i | input | 1 | Write a register entry |
| reg_ent_i | input | 16 | Register entry (layout in R2) |
| pred_wr_i | input | 1 | Write a predicate entry |
| pred_ent_i | input | 16 | Predicate entry (layout in R9) |
| lk_valid_i | input | 1 | Lookup request; starts a mask fetch |
| lk_reg_i | input | 5 | Register number from the opcode |
| lk_fp_i | input | 1 | 1 = floating-point register file |
| lk_redir_o | output | 7 | Redirected register index |
| lk_isvec_o | output | 1 | Register is a vector |
| lk_ew_o | output | 2 | Element-width code |
| rf_raddr_o | output | 5 | Integer register file read address |
| rf_rdata_i | input | XLEN | Read data, one cycle after the address |
| pred_valid_o | output | 1 | Mask result valid |
| pred_mask_o | output | XLEN | Element predicate mask |
| pred_zero_o | output | 1 | Zeroing of masked-out elements |
| pred_ffirst_o | output | 1 | Fail-on-first mode |
| pred_illegal_o | output | 1 | Reserved encoding; raise illegal-instruction trap |

## Verification
The redirect, vector flag, element width and read address are combinational. The bench drives a lookup just after a falling edge and samples these outputs a moment later, within that same cycle. Table writes and clears are held across one rising edge, and the next lookup starts after that edge, which covers the one-cycle write latency. The mask, flags and valid signal are registered once after the register-file read. The bench therefore samples them at the falling edge that follows the next rising edge, against a register-file model that also answers one cycle after the address.

// File: rtl/regpred_pkg.sv
package regpred_pkg;
   localparam int unsigned ENT_W = 16;

   // register table entry as written by software
   typedef struct packed {
      logic [4:0] key;
      logic       is_fp;
      logic [1:0] ew;
      logic       is_vec;
      logic [6:0] tgt;
   } reg_ent_t;

   // predicate table entry as written by software
   typedef struct packed {
      logic [6:0] key;
      logic       is_fp;
      logic       zero;
      logic       inv;
      logic       ffirst;
      logic [4:0] preg;
   } pred_ent_t;

   // expanded per-register slots
   typedef struct packed {
      logic       en;
      logic       is_vec;
      logic [1:0] ew;
      logic [6:0] tgt;
   } reg_slot_t;

   typedef struct packed {
      logic       en;
      logic       zero;
      logic       inv;
      logic       ffirst;
      logic [4:0] preg;
   } pred_slot_t;
endpackage

// File: rtl/regpred_wrgate.sv
module regpred_wrgate #(
   parameter int unsigned DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic wr_i,
   output logic accept_o
);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt_q;

   assign accept_o = wr_i & ~clear_i & (cnt_q < CW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clear_i)  cnt_q <= '0;
      else if (accept_o) cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/regpred_regmap.sv
module regpred_regmap
   import regpred_pkg::*;
#(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned DEPTH    = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clear_i,
   input  logic      wr_i,
   input  reg_ent_t  ent_i,
   input  logic [4:0] lk_reg_i,
   input  logic      lk_fp_i,
   output reg_slot_t slot_o
);
   localparam int unsigned RW = $clog2(NUM_REGS);

   logic            acc;
   reg_slot_t [1:0] file_slot;

   regpred_wrgate #(.DEPTH(DEPTH)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear_i),
      .wr_i    (wr_i),
      .accept_o(acc)
   );

   for (genvar f = 0; f < 2; f++) begin : g_file
      reg_slot_t tbl [NUM_REGS];
      logic      hit_file;

      assign hit_file = acc & (ent_i.is_fp == 1'(f));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) tbl[r] <= '0;
         end else if (clear_i) begin
            for (int r = 0; r < NUM_REGS; r++) tbl[r] <= '0;
         end else if (hit_file) begin
            for (int r = 0; r < NUM_REGS; r++) begin
               if (ent_i.key == 5'(r)) begin
                  tbl[r].en     <= 1'b1;
                  tbl[r].is_vec <= ent_i.is_vec;
                  tbl[r].ew     <= ent_i.ew;
                  tbl[r].tgt    <= ent_i.tgt;
               end
            end
         end
      end

      assign file_slot[f] = tbl[lk_reg_i[RW-1:0]];
   end

   assign slot_o = file_slot[lk_fp_i];
endmodule

// File: rtl/regpred_predmap.sv
module regpred_predmap
   import regpred_pkg::*;
#(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned DEPTH    = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear_i,
   input  logic       wr_i,
   input  pred_ent_t  ent_i,
   input  logic [4:0] lk_reg_i,
   input  logic       lk_fp_i,
   output pred_slot_t slot_o
);
   localparam int unsigned RW = $clog2(NUM_REGS);

   logic             acc;
   pred_slot_t [1:0] file_slot;

   regpred_wrgate #(.DEPTH(DEPTH)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear_i),
      .wr_i    (wr_i),
      .accept_o(acc)
   );

   for (genvar f = 0; f < 2; f++) begin : g_file
      pred_slot_t tbl [NUM_REGS];
      logic       hit_file;

      assign hit_file = acc & (ent_i.is_fp == 1'(f));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) tbl[r] <= '0;
         end else if (clear_i) begin
            for (int r = 0; r < NUM_REGS; r++) tbl[r] <= '0;
         end else if (hit_file) begin
            for (int r = 0; r < NUM_REGS; r++) begin
               if (ent_i.key[4:0] == 5'(r)) begin
                  tbl[r].en     <= 1'b1;
                  tbl[r].zero   <= ent_i.zero;
                  tbl[r].inv    <= ent_i.inv;
                  tbl[r].ffirst <= ent_i.ffirst;
                  tbl[r].preg   <= ent_i.preg;
               end
            end
         end
      end

      assign file_slot[f] = tbl[lk_reg_i[RW-1:0]];
   end

   assign slot_o = file_slot[lk_fp_i];
endmodule

// File: rtl/regpred_maskgen.sv
module regpred_maskgen
   import regpred_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lk_valid_i,
   input  logic            found_i,
   input  pred_slot_t      slot_i,
   input  logic [XLEN-1:0] rf_rdata_i,
   output logic            valid_o,
   output logic [XLEN-1:0] mask_o,
   output logic            zero_o,
   output logic            ffirst_o,
   output logic            illegal_o
);
   logic v_q, en_q, inv_q, zero_q, ff_q, x0_q, rsv_q;
   logic rsv_d;
   logic [XLEN-1:0] raw, shaped;

   assign rsv_d = found_i & (slot_i.preg == 5'd0) & slot_i.zero & slot_i.inv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= 1'b0; en_q <= 1'b0; inv_q <= 1'b0; zero_q <= 1'b0;
         ff_q <= 1'b0; x0_q <= 1'b0; rsv_q <= 1'b0;
      end else begin
         v_q    <= lk_valid_i;
         en_q   <= lk_valid_i & found_i;
         inv_q  <= slot_i.inv;
         zero_q <= slot_i.zero;
         ff_q   <= slot_i.ffirst;
         x0_q   <= (slot_i.preg == 5'd0);
         rsv_q  <= lk_valid_i & rsv_d;
      end
   end

   assign raw    = x0_q ? '0 : rf_rdata_i;
   assign shaped = inv_q ? ~raw : raw;

   always_comb begin
      if (rsv_q)      mask_o = '0;
      else if (en_q)  mask_o = shaped;
      else            mask_o = '1;
   end

   assign valid_o   = v_q;
   assign zero_o    = en_q & ~rsv_q & zero_q;
   assign ffirst_o  = en_q & ~rsv_q & ff_q;
   assign illegal_o = rsv_q;
endmodule

// File: rtl/regpred_lookup.sv
module regpred_lookup
   import regpred_pkg::*;
#(
   parameter int unsigned XLEN     = 64,
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned DEPTH    = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tbl_clear_i,
   input  logic            reg_wr_i,
   input  logic [15:0]     reg_ent_i,
   input  logic            pred_wr_i,
   input  logic [15:0]     pred_ent_i,
   input  logic            lk_valid_i,
   input  logic [4:0]      lk_reg_i,
   input  logic            lk_fp_i,
   output logic [6:0]      lk_redir_o,
   output logic            lk_isvec_o,
   output logic [1:0]      lk_ew_o,
   output logic [4:0]      rf_raddr_o,
   input  logic [XLEN-1:0] rf_rdata_i,
   output logic            pred_valid_o,
   output logic [XLEN-1:0] pred_mask_o,
   output logic            pred_zero_o,
   output logic            pred_ffirst_o,
   output logic            pred_illegal_o
);
   if (XLEN < 8 || XLEN > 1024) begin : g_bad_xlen
      $error("regpred_lookup: XLEN out of range");
   end
   if (NUM_REGS < 2 || NUM_REGS > 32 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $error("regpred_lookup: NUM_REGS must be a power of two up to 32");
   end
   if (DEPTH < 1 || DEPTH > 16) begin : g_bad_depth
      $error("regpred_lookup: DEPTH out of range");
   end

   reg_slot_t  rslot;
   pred_slot_t pslot;
   logic       found;

   regpred_regmap #(.NUM_REGS(NUM_REGS), .DEPTH(DEPTH)) u_regmap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (tbl_clear_i),
      .wr_i    (reg_wr_i),
      .ent_i   (reg_ent_t'(reg_ent_i)),
      .lk_reg_i(lk_reg_i),
      .lk_fp_i (lk_fp_i),
      .slot_o  (rslot)
   );

   regpred_predmap #(.NUM_REGS(NUM_REGS), .DEPTH(DEPTH)) u_predmap (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (tbl_clear_i),
      .wr_i    (pred_wr_i),
      .ent_i   (pred_ent_t'(pred_ent_i)),
      .lk_reg_i(lk_reg_i),
      .lk_fp_i (lk_fp_i),
      .slot_o  (pslot)
   );

   assign found      = rslot.en & pslot.en;
   assign lk_isvec_o = rslot.en & rslot.is_vec;
   assign lk_redir_o = lk_isvec_o ? rslot.tgt : {2'b00, lk_reg_i};
   assign lk_ew_o    = rslot.en ? rslot.ew : 2'b00;
   assign rf_raddr_o = found ? pslot.preg : 5'd0;

   regpred_maskgen #(.XLEN(XLEN)) u_maskgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_valid_i(lk_valid_i),
      .found_i   (found),
      .slot_i    (pslot),
      .rf_rdata_i(rf_rdata_i),
      .valid_o   (pred_valid_o),
      .mask_o    (pred_mask_o),
      .zero_o    (pred_zero_o),
      .ffirst_o  (pred_ffirst_o),
      .illegal_o (pred_illegal_o)
   );
endmodule

// File: rtl/regpred_lookup_chk.sv
module regpred_lookup_chk #(
   parameter int unsigned XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tbl_clear_i,
   input logic            lk_valid_i,
   input logic [4:0]      lk_reg_i,
   input logic [6:0]      lk_redir_o,
   input logic            lk_isvec_o,
   input logic            pred_valid_o,
   input logic [XLEN-1:0] pred_mask_o,
   input logic            pred_zero_o,
   input logic            pred_illegal_o
);
   assert_result_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pred_valid_o == $past(lk_valid_i));

   assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(tbl_clear_i) |-> !lk_isvec_o);

   assert_scalar_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_isvec_o |-> (lk_redir_o == {2'b00, lk_reg_i}));

   assert_reserved_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pred_illegal_o |-> (pred_mask_o == '0 && !pred_zero_o && pred_valid_o));

   assert_reserved_from_lookup_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pred_illegal_o |-> $past(lk_valid_i));
endmodule

bind regpred_lookup regpred_lookup_chk #(.XLEN(XLEN)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tbl_clear_i   (tbl_clear_i),
   .lk_valid_i    (lk_valid_i),
   .lk_reg_i      (lk_reg_i),
   .lk_redir_o    (lk_redir_o),
   .lk_isvec_o    (lk_isvec_o),
   .pred_valid_o  (pred_valid_o),
   .pred_mask_o   (pred_mask_o),
   .pred_zero_o   (pred_zero_o),
   .pred_illegal_o(pred_illegal_o)
);

// File: tb/regpred_lookup_tb.sv
module regpred_lookup_tb;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN  = 64;
   localparam int DEPTH = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tbl_clear = 1'b0, reg_wr = 1'b0, pred_wr = 1'b0, lk_valid = 1'b0, lk_fp = 1'b0;
   logic [15:0] reg_ent = '0, pred_ent = '0;
   logic [4:0]  lk_reg = '0;
   logic [6:0]  redir;
   logic        isvec, pvalid, pzero, pff, pill;
   logic [1:0]  ew;
   logic [4:0]  raddr;
   logic [XLEN-1:0] rdata = '0, pmask;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   // bench model
   logic [XLEN-1:0] rf_m [32];
   bit       m_ren [2][32]; bit m_rvec [2][32]; logic [1:0] m_rew [2][32]; logic [6:0] m_rtgt [2][32];
   bit       m_pen [2][32]; bit m_pz [2][32]; bit m_pi [2][32]; bit m_pf [2][32]; logic [4:0] m_pr [2][32];
   int       m_rcnt = 0, m_pcnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regpred_lookup #(.XLEN(XLEN), .NUM_REGS(32), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .tbl_clear_i(tbl_clear),
      .reg_wr_i(reg_wr), .reg_ent_i(reg_ent), .pred_wr_i(pred_wr), .pred_ent_i(pred_ent),
      .lk_valid_i(lk_valid), .lk_reg_i(lk_reg), .lk_fp_i(lk_fp),
      .lk_redir_o(redir), .lk_isvec_o(isvec), .lk_ew_o(ew), .rf_raddr_o(raddr),
      .rf_rdata_i(rdata), .pred_valid_o(pvalid), .pred_mask_o(pmask),
      .pred_zero_o(pzero), .pred_ffirst_o(pff), .pred_illegal_o(pill)
   );

   // register file with one cycle read latency
   always_ff @(posedge clk) rdata <= rf_m[raddr];

   function automatic logic [15:0] mk_reg(input int key, input bit fp, input int e, input bit vec, input int tgt);
      return {5'(key), fp, 2'(e), vec, 7'(tgt)};
   endfunction

   function automatic logic [15:0] mk_pred(input int key, input bit fp, input bit z, input bit inv, input bit ff, input int pr);
      return {7'(key), fp, z, inv, ff, 5'(pr)};
   endfunction

   task automatic chk(input string tag, input string what, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic clear_all(input bit with_wr);
      tbl_clear = 1'b1; reg_wr = with_wr; reg_ent = mk_reg(7, 0, 1, 1, 99);
      @(posedge clk);
      for (int f = 0; f < 2; f++) for (int r = 0; r < 32; r++) begin
         m_ren[f][r] = 0; m_pen[f][r] = 0;
      end
      m_rcnt = 0; m_pcnt = 0;
      @(negedge clk);
      tbl_clear = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic wr_reg(input logic [15:0] e);
      reg_wr = 1'b1; reg_ent = e;
      @(posedge clk);
      if (m_rcnt < DEPTH) begin
         m_rcnt++;
         m_ren[e[10]][e[15:11]] = 1; m_rvec[e[10]][e[15:11]] = e[7];
         m_rew[e[10]][e[15:11]] = e[9:8]; m_rtgt[e[10]][e[15:11]] = e[6:0];
      end
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wr_pred(input logic [15:0] e);
      pred_wr = 1'b1; pred_ent = e;
      @(posedge clk);
      if (m_pcnt < DEPTH) begin
         m_pcnt++;
         m_pen[e[8]][e[13:9]] = 1; m_pz[e[8]][e[13:9]] = e[7];
         m_pi[e[8]][e[13:9]] = e[6]; m_pf[e[8]][e[13:9]] = e[5]; m_pr[e[8]][e[13:9]] = e[4:0];
      end
      @(negedge clk);
      pred_wr = 1'b0;
   endtask

   task automatic lookup(input int r, input bit fp, input string tag);
      bit vec, found, rsv;
      logic [XLEN-1:0] raw, emask;
      lk_reg = 5'(r); lk_fp = fp; lk_valid = 1'b1;
      #1;
      vec   = m_ren[fp][r] && m_rvec[fp][r];
      found = m_ren[fp][r] && m_pen[fp][r];
      rsv   = found && m_pr[fp][r] == 0 && m_pz[fp][r] && m_pi[fp][r];
      chk(tag, "redirect", XLEN'(redir), vec ? XLEN'(m_rtgt[fp][r]) : XLEN'(r));
      chk(tag, "isvec", XLEN'(isvec), XLEN'(vec));
      chk(tag, "ew", XLEN'(ew), m_ren[fp][r] ? XLEN'(m_rew[fp][r]) : '0);
      chk(tag, "raddr R7", XLEN'(raddr), found ? XLEN'(m_pr[fp][r]) : '0);
      raw = (found && m_pr[fp][r] != 0) ? rf_m[m_pr[fp][r]] : '0;
      if (!found)           emask = '1;
      else if (rsv)         emask = '0;
      else if (m_pi[fp][r]) emask = ~raw;
      else                  emask = raw;
      @(posedge clk);
      @(negedge clk);
      chk(tag, "valid R7", XLEN'(pvalid), 1);
      chk(tag, "mask", pmask, emask);
      chk(tag, "zero R12", XLEN'(pzero), XLEN'(found && !rsv && m_pz[fp][r]));
      chk(tag, "ffirst R12", XLEN'(pff), XLEN'(found && !rsv && m_pf[fp][r]));
      chk(tag, "illegal R11", XLEN'(pill), XLEN'(rsv));
      lk_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < 32; i++) rf_m[i] = {$urandom, $urandom};
      rf_m[0] = '0;
      for (int f = 0; f < 2; f++) for (int r = 0; r < 32; r++) begin
         m_ren[f][r] = 0; m_pen[f][r] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      lookup(5, 0, "R1");
      lookup(3, 1, "R8");
      wr_reg(mk_reg(5, 0, 2, 1, 100));
      wr_reg(mk_reg(6, 0, 1, 0, 77));
      lookup(5, 0, "R2");
      lookup(6, 0, "R2");
      lookup(5, 1, "R3");
      wr_pred(mk_pred(5, 0, 0, 1, 1, 3));
      wr_pred(mk_pred(9, 0, 1, 0, 0, 4));
      lookup(9, 0, "R8");
      lookup(5, 0, "R9");
      wr_reg(mk_reg(5, 0, 3, 1, 20));
      lookup(5, 0, "R4");
      wr_reg(mk_reg(5, 1, 0, 1, 33));
      lookup(5, 1, "R3");
      wr_reg(mk_reg(7, 0, 1, 1, 90));
      lookup(7, 0, "R5");
      wr_pred(mk_pred(6, 0, 0, 1, 0, 0));
      lookup(6, 0, "R10");
      wr_pred(mk_pred(5, 0, 1, 1, 0, 0));
      lookup(5, 0, "R11");
      wr_pred(mk_pred(6, 0, 1, 0, 1, 7));
      lookup(6, 0, "R5");
      clear_all(1'b1);
      lookup(7, 0, "R6");
      lookup(5, 0, "R6");
      wr_reg(mk_reg(2, 0, 1, 1, 40));
      wr_pred(mk_pred(2, 0, 1, 0, 1, 8));
      lookup(2, 0, "R12");

      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom % 12);
         if (op == 0)
            clear_all(1'($urandom));
         else if (op <= 3)
            wr_reg(mk_reg(int'($urandom % 8), 1'($urandom), int'($urandom % 4),
                          1'($urandom), int'($urandom % 128)));
         else if (op <= 6)
            wr_pred(mk_pred(int'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom),
                            1'($urandom), int'($urandom % 4)));
         else
            lookup(int'($urandom % 8), 1'($urandom), "random R2 R9");
      end

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule